// File: doc/BRIEF.md
# Interval Timer Scan Trigger

This block produces the internal start pulses for two conversion queues that run in interval-timer single-scan mode. Each queue has its own single-scan enable bit, held by software in a register outside this block, while one four-bit interval select is shared by both queues. When a queue's enable is seen high and the select holds a legal code, that queue's timer starts from zero. The timer advances only on cycles where the converter-clock enable input is high. When the chosen power-of-two interval has passed, the block raises that queue's trigger for exactly one cycle. The sequencer takes this pulse as "start at the first command".

After firing, a queue's timer does nothing until the sequencer reports the end of the scan on its scan-done input. The timer then waits for the enable bit to go low. The sequencer normally clears that bit, and software must set it again before the next interval starts. The queue sequencer, register access and continuous-scan modes are outside this block. The trigger outputs and the scan-done inputs are its whole interface to the sequencer.

Each queue has its own state machine with four states. `ST_IDLE` waits for enable and a legal code, then moves to `ST_COUNT` (arm). `ST_COUNT` counts enabled cycles. It returns to `ST_IDLE` if the enable drops or the code becomes illegal (abort). It moves to `ST_WAIT_DONE` and fires on the enabled cycle where the count reaches the interval (expire). `ST_WAIT_DONE` moves to `ST_REARM` when scan-done is seen (complete). `ST_REARM` goes back to `ST_IDLE` once the enable is low (release).

Top module: `interval_scan_trigger`

## Requirements
- R1: While reset is active, and on the first cycle after it, both trigger outputs are low and no timer is counting.
- R2: With select code n (0 to 10) and the clock enable held high, suppose a queue's enable is first sampled high at clock edge k. Its trigger bit is then high during the cycle after edge k + 2^(n+7), and low before that.
- R3: The timer advances only on edges where `qclk_en` is high. With the clock enable high every other cycle, the trigger comes about twice as late (code 0: 254 to 258 cycles).
- R4: Each trigger is a pulse exactly one cycle wide.
- R5: Select codes 11 to 15 never produce a trigger. A timer that is counting gives up its count if the code becomes one of these values.
- R6: If a queue's enable drops before its interval elapses, no trigger is produced. Setting the enable again starts a full interval from zero.
- R7: After a trigger, that queue produces no further trigger while its enable stays high, whether or not scan-done has arrived. A new interval starts only after scan-done has been seen and the enable has gone low and then high again.
- R8: The two queues are independent. Bit 0 of the `arm_en`, `scan_done` and `trig` buses belongs to queue 0 and bit 1 to queue 1. If both reach their interval on the same edge, both trigger bits are high in the same cycle.
- R9: The interval limit is 2^17 cycles at code 10. The counter reaches it without wrapping early.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qclk_en | input | 1 | Converter clock enable; the timers advance only when it is high |
| ival_sel | input | 4 | Shared interval select; code n gives 2^(n+7) cycles, codes 11 to 15 are off |
| arm_en | input | 2 | Single-scan enable bit for each queue (bit 0 is queue 0) |
| scan_done | input | 2 | End-of-scan pulse from the sequencer, one bit per queue |
| trig | output | 2 | One-cycle start trigger for each queue |

## Verification
The bench measures the trigger edge exactly at several codes, including the 2^17 limit. A counter that is off by one, or that wraps too early, would fire one edge early or late, or much too soon. It gates the clock enable every other cycle, so a timer that counts raw clocks would fire at about half the expected delay. It also removes the enable partway through an interval, and keeps the enable high after firing both with and without scan-done. A design that held a stale count, or that re-armed on a level rather than on a fresh set, would trigger where it must stay silent. Finally, it arms both queues together, so that an arbitration shortcut that drops one of two simultaneous triggers is caught.

// File: rtl/ist_pkg.sv
package ist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_COUNT     = 2'd1,
        ST_WAIT_DONE = 2'd2,
        ST_REARM     = 2'd3
    } tmr_state_e;

endpackage

// File: rtl/ist_interval_decode.sv
module ist_interval_decode #(
    parameter int CODE_W     = 4,
    parameter int BASE_SHIFT = 7,
    parameter int NUM_CODES  = 11,
    localparam int CNT_W     = BASE_SHIFT + NUM_CODES - 1
) (
    input  logic [CODE_W-1:0] sel,
    output logic [CNT_W-1:0]  term,
    output logic              term_valid
);

    logic [CNT_W:0] span;

    always_comb begin
        term_valid = (int'(sel) < NUM_CODES);
        span       = '0;
        for (int c = 0; c < NUM_CODES; c++) begin
            if (int'(sel) == c) begin
                span = (CNT_W+1)'(1) << (c + BASE_SHIFT);
            end
        end
        // Last count value before expiry; zero span (illegal code) is masked by term_valid.
        term = CNT_W'(span - 1'b1);
    end

endmodule

// File: rtl/ist_queue_timer.sv
module ist_queue_timer
    import ist_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             arm,
    input  logic             done,
    input  logic [CNT_W-1:0] term,
    input  logic             term_valid,
    output logic             fire
);

    tmr_state_e       state_q;
    tmr_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             expire;

    // Greater-or-equal so a code lowered mid-count fires on the next tick
    // instead of wrapping.
    assign expire = (state_q == ST_COUNT) && arm && term_valid && tick && (cnt_q >= term);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm && term_valid) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (!arm || !term_valid) state_d = ST_IDLE;
                else if (expire)         state_d = ST_WAIT_DONE;
            end
            ST_WAIT_DONE: begin
                if (done) state_d = ST_REARM;
            end
            ST_REARM: begin
                if (!arm) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            fire  <= 1'b0;
        end else begin
            fire <= expire;
            if (state_q != ST_COUNT) cnt_q <= '0;
            else if (tick)           cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/interval_scan_trigger.sv
module interval_scan_trigger #(
    parameter int NUM_Q      = 2,
    parameter int CODE_W     = 4,
    parameter int BASE_SHIFT = 7,
    parameter int NUM_CODES  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              qclk_en,
    input  logic [CODE_W-1:0] ival_sel,
    input  logic [NUM_Q-1:0]  arm_en,
    input  logic [NUM_Q-1:0]  scan_done,
    output logic [NUM_Q-1:0]  trig
);

    localparam int CNT_W = BASE_SHIFT + NUM_CODES - 1;

    logic [CNT_W-1:0] term;
    logic             term_valid;

    ist_interval_decode #(
        .CODE_W     (CODE_W),
        .BASE_SHIFT (BASE_SHIFT),
        .NUM_CODES  (NUM_CODES)
    ) u_decode (
        .sel        (ival_sel),
        .term       (term),
        .term_valid (term_valid)
    );

    for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
        ist_queue_timer #(
            .CNT_W (CNT_W)
        ) u_timer (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (qclk_en),
            .arm        (arm_en[q]),
            .done       (scan_done[q]),
            .term       (term),
            .term_valid (term_valid),
            .fire       (trig[q])
        );
    end

endmodule

// File: rtl/ist_checker.sv
module ist_checker #(
    parameter int NUM_Q     = 2,
    parameter int CODE_W    = 4,
    parameter int NUM_CODES = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              qclk_en,
    input logic [CODE_W-1:0] ival_sel,
    input logic [NUM_Q-1:0]  arm_en,
    input logic [NUM_Q-1:0]  scan_done,
    input logic [NUM_Q-1:0]  trig
);

    logic [NUM_Q-1:0] pending;

    always_ff @(posedge clk) begin
        if (!rst_n) pending <= '0;
        else        pending <= (pending & ~scan_done) | trig;
    end

    // R1: trigger stays low through reset and the cycle after
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (trig == '0));

    for (genvar q = 0; q < NUM_Q; q++) begin : g_chk
        // R4: one-cycle pulse
        p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
            trig[q] |=> !trig[q]);
        // R3: firing edge had the clock enable
        p_tick_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(trig[q]) |-> $past(qclk_en));
        // R5: firing edge saw a legal code
        p_legal_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(trig[q]) |-> (int'($past(ival_sel)) < NUM_CODES));
        // R6: firing edge saw the enable high
        p_armed_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(trig[q]) |-> $past(arm_en[q]));
        // R7: no second trigger before scan-done
        p_no_retrigger_r7: assert property (@(posedge clk) disable iff (!rst_n)
            trig[q] |-> !pending[q]);
    end

endmodule

bind interval_scan_trigger ist_checker #(
    .NUM_Q     (NUM_Q),
    .CODE_W    (CODE_W),
    .NUM_CODES (NUM_CODES)
) u_ist_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .qclk_en   (qclk_en),
    .ival_sel  (ival_sel),
    .arm_en    (arm_en),
    .scan_done (scan_done),
    .trig      (trig)
);

// File: tb/sim_interval_scan_trigger.sv
`timescale 1ns/1ps
module sim_interval_scan_trigger;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       qclk_en = 1'b1;
    logic       half_rate = 1'b0;
    logic [3:0] ival_sel = 4'd0;
    logic [1:0] arm_en = 2'b00;
    logic [1:0] scan_done = 2'b00;
    logic [1:0] trig;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (half_rate) qclk_en <= ~qclk_en;
        else           qclk_en <= 1'b1;
    end

    interval_scan_trigger u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .qclk_en   (qclk_en),
        .ival_sel  (ival_sel),
        .arm_en    (arm_en),
        .scan_done (scan_done),
        .trig      (trig)
    );

    // Vector table: queue mask and select code; expected delay is 2^(code+7).
    localparam int NV = 5;
    localparam logic [1:0] V_MASK [NV] = '{2'b01, 2'b10, 2'b11, 2'b01, 2'b10};
    localparam logic [3:0] V_CODE [NV] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd0};

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: trig actual=%b expected=%b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int lo, input int hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    // Arm mask at code, check low one edge early, high on time, low after.
    task automatic measure(input string req, input logic [1:0] mask, input logic [3:0] code);
        int span;
        span = 1 << (code + 7);
        @(negedge clk);
        ival_sel = code;
        arm_en   = arm_en | mask;
        @(posedge clk);
        repeat (span - 1) @(posedge clk);
        @(negedge clk);
        chk(req, trig, 2'b00);
        @(posedge clk);
        @(negedge clk);
        chk(req, trig, mask);
        @(posedge clk);
        @(negedge clk);
        chk("R4", trig, 2'b00);
    endtask

    // Watch n cycles; return OR of trig seen.
    task automatic watch(input int n, output logic [1:0] seen);
        seen = 2'b00;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            seen = seen | trig;
        end
    endtask

    task automatic complete(input logic [1:0] mask);
        @(negedge clk);
        scan_done = mask;
        @(negedge clk);
        scan_done = 2'b00;
        arm_en    = arm_en & ~mask;
        @(negedge clk);
    endtask

    initial begin
        logic [1:0] seen;
        int         wait_cnt;

        // R1: reset
        repeat (3) @(negedge clk);
        chk("R1", trig, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", trig, 2'b00);

        // Table walk: R2 timing and R8 simultaneous queues
        for (int v = 0; v < NV; v++) begin
            measure((V_MASK[v] == 2'b11) ? "R8" : "R2", V_MASK[v], V_CODE[v]);
            complete(V_MASK[v]);
        end

        // R3: half-rate clock enable doubles the delay
        half_rate = 1'b1;
        @(negedge clk);
        ival_sel = 4'd0;
        arm_en   = 2'b01;
        wait_cnt = 0;
        seen     = 2'b00;
        while (seen == 2'b00 && wait_cnt < 1000) begin
            @(negedge clk);
            wait_cnt++;
            seen = trig;
        end
        chk_int("R3", wait_cnt, 254, 258);
        complete(2'b01);
        half_rate = 1'b0;
        repeat (2) @(negedge clk);

        // R5: illegal code never fires
        ival_sel = 4'd12;
        arm_en   = 2'b10;
        watch(400, seen);
        chk("R5", seen, 2'b00);
        arm_en = 2'b00;
        @(negedge clk);

        // R5: code turned illegal mid-count abandons the count
        ival_sel = 4'd0;
        arm_en   = 2'b01;
        watch(60, seen);
        ival_sel = 4'd15;
        watch(300, seen);
        chk("R5", seen, 2'b00);
        arm_en = 2'b00;
        @(negedge clk);

        // R6: drop enable mid-interval, then full interval from zero
        ival_sel = 4'd0;
        arm_en   = 2'b10;
        watch(100, seen);
        arm_en = 2'b00;
        watch(200, seen);
        chk("R6", seen, 2'b00);
        measure("R6", 2'b10, 4'd0);
        complete(2'b10);

        // R7: no retrigger while enable stays high, with and without scan-done
        measure("R2", 2'b01, 4'd0);
        watch(300, seen);
        chk("R7", seen, 2'b00);
        scan_done = 2'b01;
        @(negedge clk);
        scan_done = 2'b00;
        watch(300, seen);
        chk("R7", seen, 2'b00);
        arm_en = 2'b00;
        @(negedge clk);
        measure("R7", 2'b01, 4'd0);
        complete(2'b01);

        // R9: longest interval
        measure("R9", 2'b10, 4'd10);
        complete(2'b10);

        finished = 1'b1;
    end

    initial begin
        while (!finished && cycles < 190000) begin
            @(posedge clk);
            cycles++;
        end
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, actual=%0d cycles expected<190000", cycles);
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule